// File: doc/BRIEF.md
# Security Register Serial Read Responder

This block is the slave side of a four-wire serial link (active-low select, serial clock, data in, data out). It answers one command, a read of a 128-byte one-time-programmable security register, and streams the register contents back one bit per clock. A command is an 8-bit opcode, a 24-bit start address and 16 dummy bits. After the last dummy bit, every further serial clock shifts out register data. The read runs past the top byte and continues from byte zero with no break. Releasing the select ends the transfer at any point, even in the middle of a byte.

The serial pins are oversampled by a system clock through synchronizer stages. The serial clock must therefore stay low and high for at least four system clocks each. Output enable is a separate port, so the pad ring builds the tri-state buffer: `spi_miso_oe` low means the data line is in high impedance. The register contents are loaded through a parallel byte-write port intended for test.

Top module: `otp_secreg_reader`

## Requirements
- R1: With `spi_cs_n` low, the first eight bits sampled on rising `spi_sclk` edges, MSB first, form the opcode. Only the value 77h starts a read.
- R2: The 24 bits after the opcode are the start address, sent MSB first. Only the last seven of them (A6..A0) choose the first byte. A23..A7 have no effect.
- R3: The 16 bits after the address are dummy bits. Their values have no effect on the data that follows.
- R4: `spi_miso_oe` stays low during the opcode, address and dummy bits. It goes high on the first falling `spi_sclk` edge after the last dummy bit, and bit 7 of the first byte is valid before the next rising edge.
- R5: Data leaves MSB first, one bit per falling `spi_sclk` edge. Each byte is followed directly by the byte at the next address.
- R6: After byte 7Fh the stream continues with byte 00h, with no missing or extra clock.
- R7: Raising `spi_cs_n` at any point, including mid-byte, drives `spi_miso_oe` low within four system clocks.
- R8: While enabled, `spi_miso` changes only in response to a falling `spi_sclk` edge. It holds steady through the high half of the serial clock.
- R9: Any opcode other than 77h keeps `spi_miso_oe` low for all further serial clocks until `spi_cs_n` is raised.
- R10: Raising `spi_cs_n` clears the bit count and phase, so the next select starts a fresh opcode even after an aborted command.
- R11: A system clock edge with `pre_we` high stores `pre_wdata` into the byte at `pre_addr`. Later reads return the new value.
- R12: While `rst_n` is low at a system clock edge, the block returns to idle with `spi_miso_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial data out of the block |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | 7 | Preload byte address |
| pre_wdata | input | 8 | Preload byte value |

## Verification
A wrong phase count or a wrong opcode decision shows on the first falling edge where output enable should change. Either `spi_miso_oe` rises during the dummy bits, or it stays low where data is due, and the per-bit comparison catches this within one serial clock. A bad address counter or a bad wrap shows as a wrong bit inside the first byte that uses it. Crossing 7Fh is checked at the exact bit. Stale phase state left by an abort shows on the very next command as missing or misplaced data.

// File: rtl/osr_pkg.sv
// Package: shared phase encoding for the security register read responder.
// Assumes: used by every module of the block and by its checker.
package osr_pkg;

    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ADR  = 3'd1,
        PH_DMY  = 3'd2,
        PH_DAT  = 3'd3,
        PH_SKIP = 3'd4
    } osr_phase_e;

endpackage

// File: rtl/osr_pin_sync.sv
// Module: osr_pin_sync
// Brings the select, serial clock and serial data pins into the system
// clock domain. Provides a select-active level plus one-cycle strobes for
// rising and falling serial clock edges.
// Assumes: each serial clock level lasts longer than STAGES + 1 system clocks.
module osr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_in,
    input  logic sclk_in,
    input  logic mosi_in,
    output logic sel,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic mosi_s
);

    // bit 2: select (active low), bit 1: serial clock, bit 0: serial data
    logic [2:0] pipe [STAGES];
    logic       sclk_prev;
    logic       sclk_s;

    // first synchronizer stage; reset parks select inactive
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= 3'b100;
        else        pipe[0] <= {cs_n_in, sclk_in, mosi_in};
    end

    // remaining synchronizer stages
    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= 3'b100;
                else        pipe[g] <= pipe[g-1];
            end
        end
    endgenerate

    assign sel    = ~pipe[STAGES-1][2];
    assign sclk_s = pipe[STAGES-1][1];
    assign mosi_s = pipe[STAGES-1][0];

    // previous synchronized serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign sclk_rise = sel &  sclk_s & ~sclk_prev;
    assign sclk_fall = sel & ~sclk_s &  sclk_prev;

endmodule

// File: rtl/osr_cmd_ctrl.sv
// Module: osr_cmd_ctrl
// Walks the command phases on rising serial clock edges: opcode, address,
// dummy, then data. A foreign opcode parks it in a skip phase. Only the
// low address bits are kept, so higher address bits simply fall out.
// Assumes: DUMMY_BYTES >= 1, ADDR_BYTES*8 >= ADDR_BITS >= 2.
module osr_cmd_ctrl
    import osr_pkg::*;
#(
    parameter logic [7:0] OPCODE      = 8'h77,
    parameter int         ADDR_BITS   = 7,
    parameter int         ADDR_BYTES  = 3,
    parameter int         DUMMY_BYTES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic                 sclk_rise,
    input  logic                 mosi_s,
    output osr_phase_e           phase,
    output logic                 start,
    output logic [ADDR_BITS-1:0] start_addr
);

    localparam int ADR_LEN = 8 * ADDR_BYTES;
    localparam int DMY_LEN = 8 * DUMMY_BYTES;
    localparam int MAX_LEN = (ADR_LEN > DMY_LEN) ? ADR_LEN : DMY_LEN;
    localparam int CNT_W   = $clog2(MAX_LEN) + 1;

    logic [CNT_W-1:0]     bit_cnt;
    logic [6:0]           opc_sh;
    logic [ADDR_BITS-1:0] adr_sh;
    logic [7:0]           opc_next;

    assign opc_next   = {opc_sh, mosi_s};
    assign start_addr = adr_sh;

    // phase sequencing and shift capture; deselect restarts the command
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase   <= PH_OPC;
            bit_cnt <= '0;
            opc_sh  <= '0;
            adr_sh  <= '0;
            start   <= 1'b0;
        end else begin
            start <= 1'b0;
            if (sclk_rise) begin
                case (phase)
                    PH_OPC: begin
                        opc_sh <= opc_next[6:0];
                        if (bit_cnt == CNT_W'(7)) begin
                            bit_cnt <= '0;
                            phase   <= (opc_next == OPCODE) ? PH_ADR : PH_SKIP;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_ADR: begin
                        adr_sh <= {adr_sh[ADDR_BITS-2:0], mosi_s};
                        if (bit_cnt == CNT_W'(ADR_LEN - 1)) begin
                            bit_cnt <= '0;
                            phase   <= PH_DMY;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_DMY: begin
                        if (bit_cnt == CNT_W'(DMY_LEN - 1)) begin
                            bit_cnt <= '0;
                            phase   <= PH_DAT;
                            start   <= 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/osr_reg_store.sv
// Module: osr_reg_store
// Byte storage for the security register. It has a parallel preload write
// port and an asynchronous read port for the transmitter.
// Assumes: BYTES is a power of two, so every read address is in range.
module osr_reg_store #(
    parameter int BYTES = 128,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [BYTES];

    // preload write
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/osr_tx_shift.sv
// Module: osr_tx_shift
// Streams register bytes MSB first, one bit per falling serial clock edge.
// It fetches the next byte at each byte boundary and lets the address
// counter wrap naturally at the register size.
// Assumes: start pulses once, on a rising edge, before the first data fall.
module osr_tx_shift #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          sclk_fall,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          miso,
    output logic          miso_oe
);

    logic       active;
    logic [2:0] bits_left;
    logic [6:0] byte_sh;

    // output bit launch, byte fetch and address advance
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            active    <= 1'b0;
            miso_oe   <= 1'b0;
            miso      <= 1'b0;
            bits_left <= '0;
            byte_sh   <= '0;
            rd_addr   <= '0;
        end else if (start) begin
            active    <= 1'b1;
            rd_addr   <= start_addr;
            bits_left <= '0;
        end else if (active && sclk_fall) begin
            miso_oe <= 1'b1;
            if (bits_left == 3'd0) begin
                miso      <= rd_data[7];
                byte_sh   <= rd_data[6:0];
                bits_left <= 3'd7;
                rd_addr   <= rd_addr + AW'(1);
            end else begin
                miso      <= byte_sh[6];
                byte_sh   <= {byte_sh[5:0], 1'b0};
                bits_left <= bits_left - 3'd1;
            end
        end
    end

endmodule

// File: rtl/otp_secreg_reader.sv
// Module: otp_secreg_reader (top)
// Serial slave that answers the security register read command. It joins
// the pin synchronizer, command sequencer, byte storage and bit transmitter.
// Assumes: serial clock idles low (mode 0); the pad ring builds the
// tri-state buffer from spi_miso and spi_miso_oe.
module otp_secreg_reader
    import osr_pkg::*;
#(
    parameter int         REG_BYTES   = 128,
    parameter logic [7:0] OPCODE      = 8'h77,
    parameter int         ADDR_BYTES  = 3,
    parameter int         DUMMY_BYTES = 2,
    parameter int         SYNC_STAGES = 2,
    localparam int        AW          = $clog2(REG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          spi_cs_n,
    input  logic          spi_sclk,
    input  logic          spi_mosi,
    output logic          spi_miso,
    output logic          spi_miso_oe,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [7:0]    pre_wdata
);

    logic          sel;
    logic          sclk_rise;
    logic          sclk_fall;
    logic          mosi_s;
    osr_phase_e    phase;
    logic          start;
    logic [AW-1:0] start_addr;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    osr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_in   (spi_cs_n),
        .sclk_in   (spi_sclk),
        .mosi_in   (spi_mosi),
        .sel       (sel),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s)
    );

    osr_cmd_ctrl #(
        .OPCODE      (OPCODE),
        .ADDR_BITS   (AW),
        .ADDR_BYTES  (ADDR_BYTES),
        .DUMMY_BYTES (DUMMY_BYTES)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sclk_rise  (sclk_rise),
        .mosi_s     (mosi_s),
        .phase      (phase),
        .start      (start),
        .start_addr (start_addr)
    );

    osr_reg_store #(.BYTES(REG_BYTES), .AW(AW)) u_store (
        .clk   (clk),
        .we    (pre_we),
        .waddr (pre_addr),
        .wdata (pre_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    osr_tx_shift #(.AW(AW)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .sclk_fall  (sclk_fall),
        .start      (start),
        .start_addr (start_addr),
        .rd_data    (rd_data),
        .rd_addr    (rd_addr),
        .miso       (spi_miso),
        .miso_oe    (spi_miso_oe)
    );

endmodule

// File: rtl/osr_chk.sv
// Module: osr_chk
// Protocol checker bound into otp_secreg_reader. It watches the phase,
// the synchronized edge strobes and the output pins.
// Assumes: bound by the statement at the end of this file.
module osr_chk
    import osr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sel,
    input logic       sclk_fall,
    input osr_phase_e phase,
    input logic       spi_miso,
    input logic       spi_miso_oe
);

    // R4: output is enabled only in the data phase
    assert_oe_only_in_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso_oe |-> phase == PH_DAT);

    // R4: output enable turns on only because of a falling serial edge
    assert_oe_rise_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_miso_oe) |-> $past(sclk_fall));

    // R7: deselect turns the output off on the next cycle
    assert_deselect_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !spi_miso_oe);

    // R8: data changes only after a falling serial edge while driven
    assert_miso_moves_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_miso_oe && !$stable(spi_miso)) |-> $past(sclk_fall));

    // R9: a rejected opcode never drives the line
    assert_skip_stays_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_SKIP |-> !spi_miso_oe);

    // R10: deselect returns the sequencer to the opcode phase
    assert_fresh_after_deselect_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> phase == PH_OPC);

endmodule

bind otp_secreg_reader osr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (sel),
    .sclk_fall   (sclk_fall),
    .phase       (phase),
    .spi_miso    (spi_miso),
    .spi_miso_oe (spi_miso_oe)
);

// File: tb/otp_secreg_reader_bench.sv
// Bench for otp_secreg_reader: a behavioural reference model (byte array
// plus a queue of expected bits) checked at every serial bit and at every
// system clock while the select is released.
module otp_secreg_reader_bench;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;     // system clocks per serial clock level

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       spi_miso_oe;
    logic       pre_we = 1'b0;
    logic [6:0] pre_addr = '0;
    logic [7:0] pre_wdata = '0;

    int         checks = 0;
    int         fails = 0;
    int         idle_clks = 0;
    logic [7:0] ref_mem [128];
    bit         exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    otp_secreg_reader u_otp_secreg_reader (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .spi_miso_oe (spi_miso_oe),
        .pre_we      (pre_we),
        .pre_addr    (pre_addr),
        .pre_wdata   (pre_wdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R7: every system clock, once select has been released for 4 clocks, line is off
    always @(negedge clk) begin
        if (rst_n && spi_cs_n) begin
            idle_clks++;
            if (idle_clks >= 4) chk(spi_miso_oe == 1'b0, "R7", spi_miso_oe, 0);
        end else begin
            idle_clks = 0;
        end
    end

    // one command-side byte, checking the line stays off (R4/R9 given by caller)
    task automatic send_byte(input logic [7:0] b, input string req);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = b[i];
            wait_clks(HALF);
            chk(spi_miso_oe == 1'b0, req, spi_miso_oe, 0);
            spi_sclk = 1'b1;
            wait_clks(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    // load the expected bit queue from the reference byte array
    task automatic model_stream(input int start, input int nbits);
        exp_q.delete();
        for (int k = 0; k < nbits; k++)
            exp_q.push_back(ref_mem[(start + k/8) % 128][7 - (k % 8)]);
    endtask

    // data phase: compare each bit before the rise and across the high half
    task automatic read_bits(input int start, input int nbits);
        model_stream(start, nbits);
        for (int k = 0; k < nbits; k++) begin
            bit    e;
            logic  m0;
            string req;
            e = exp_q.pop_front();
            wait_clks(HALF);
            req = (k == 0) ? "R4" : ((start + k/8) >= 128) ? "R6" : "R5";
            chk(spi_miso_oe == 1'b1, req, spi_miso_oe, 1);
            chk(spi_miso == e, req, spi_miso, e);
            m0 = spi_miso;
            spi_sclk = 1'b1;
            wait_clks(HALF - 1);
            chk(spi_miso == m0 && spi_miso_oe, "R8", spi_miso, m0);
            wait_clks(1);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic do_read(input logic [23:0] adr, input logic [7:0] d0,
                           input logic [7:0] d1, input int nbits);
        spi_cs_n = 1'b0;
        wait_clks(HALF);
        send_byte(8'h77, "R1");
        send_byte(adr[23:16], "R2");
        send_byte(adr[15:8], "R2");
        send_byte(adr[7:0], "R2");
        send_byte(d0, "R3");
        send_byte(d1, "R3");
        read_bits(int'(adr[6:0]), nbits);
        spi_cs_n = 1'b1;
        wait_clks(4);
        chk(spi_miso_oe == 1'b0, "R7", spi_miso_oe, 0);
        wait_clks(2 * HALF);
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        pre_we = 1'b1; pre_addr = 7'(a); pre_wdata = v;
        wait_clks(1);
        pre_we = 1'b0;
        ref_mem[a] = v;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait_clks(5);
        chk(spi_miso_oe == 1'b0, "R12", spi_miso_oe, 0);
        rst_n = 1'b1;
        wait_clks(2);
        chk(spi_miso_oe == 1'b0, "R12", spi_miso_oe, 0);

        // R11: preload every byte through the parallel port
        for (int i = 0; i < 128; i++) preload(i, 8'((i * 73 + 17) ^ (i >> 2)));

        // R1 R2 R5: plain read, upper address bits set and ignored
        do_read(24'hAB_FF10, 8'h00, 8'h00, 24);
        // R6: start near the top and cross the wrap
        do_read(24'h00_007E, 8'h00, 8'h00, 40);
        // R3: same start with different dummy values gives the same data
        do_read(24'h00_007E, 8'hFF, 8'h5A, 16);
        // R6: start exactly at the top byte
        do_read(24'h00_007F, 8'hA5, 8'h3C, 24);

        // R7: abort in the middle of a data byte
        do_read(24'h00_0040, 8'h00, 8'h00, 11);

        // R9: foreign opcode (one bit off) keeps the line off
        spi_cs_n = 1'b0;
        wait_clks(HALF);
        send_byte(8'hF7, "R9");
        for (int j = 0; j < 6; j++) send_byte(8'h00, "R9");
        spi_cs_n = 1'b1;
        wait_clks(2 * HALF);

        // R10: abort in the middle of the address, then a fresh command
        spi_cs_n = 1'b0;
        wait_clks(HALF);
        send_byte(8'h77, "R10");
        send_byte(8'h12, "R10");
        spi_cs_n = 1'b1;
        wait_clks(2 * HALF);
        do_read(24'h00_0005, 8'h00, 8'h00, 16);

        // R11: overwrite one byte and read it back
        preload(32, 8'hC3);
        do_read(24'h00_0020, 8'h00, 8'h00, 8);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule